// File: doc/BRIEF.md
# Local Countdown Interrupt Timer

The block is a countdown timer that raises a local interrupt request when its count runs out. Two registers set its behaviour, and both are written through a small write port. The first is a 32-bit vector-table entry. It holds the interrupt vector, the delivery mode, the trigger type, a mask bit, a periodic bit and three status-type bits that are only stored. The second is an initial-count register. Writing it loads the running count and starts the timer.

The count drops by one on every tick of a fixed prescaler, which divides the clock by 2**DIV_LOG2. When the count moves from 1 to 0, the timer has expired. If the entry is unmasked, the block then emits a one-cycle request that carries the vector, mode and trigger type. In periodic mode the count reloads from the initial count and keeps running. In one-shot mode it stays at zero. A read port returns the entry, the initial count or the current count at any time.

Top module: `irq_countdown_timer`

## Requirements
- R1: After a synchronous active-low reset, the entry, the initial count and the current count all read 0, and irq_req is low.
- R2: The entry written at wr_sel=0 is laid out as follows: vector in bits 7:0, delivery mode in bits 10:8, delivery-status bit 12, polarity bit 13, remote-flag bit 14, trigger bit 15 (1 means level), mask bit 16, periodic bit 17. Reading rd_sel=0 returns these bits, while bit 11 and bits 31:18 read as 0.
- R3: A write at wr_sel=1 loads both the initial count and the current count, and it restarts the prescaler. rd_sel=1 returns the initial count and rd_sel=2 returns the current count. rd_sel=3 reads 0.
- R4: While the current count is non-zero, it drops by one every 2**DIV_LOG2 clocks. The first decrement lands on the 2**DIV_LOG2-th rising edge after the edge that loaded it.
- R5: On expiry with the mask clear, irq_req is high for the one cycle that follows the expiring edge. In that same cycle irq_vector, irq_mode and irq_level carry the entry's vector, mode and trigger bit.
- R6: On expiry with the mask set, no request is raised, but the reload rule of R7/R8 still applies.
- R7: On expiry with the periodic bit set, the current count reloads from the initial count and keeps counting. An initial count of 1 expires on every prescaler tick.
- R8: On expiry with the periodic bit clear, the current count holds at 0 and no further request follows.
- R9: Writing 0 as the initial count stops the timer: the current count stays 0 and no request is raised.
- R10: When an initial-count write falls on an expiring edge, the write wins: no request is raised and the count takes the written value. When an entry write falls on an expiring edge, the request uses the entry value held before that write.
- R11: Writes at wr_sel=2 or wr_sel=3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 entry, 1 initial count, 2/3 none |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select: 0 entry, 1 initial count, 2 current count, 3 zero |
| rd_data | output | 32 | Read data (combinational) |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector sent with the request |
| irq_mode | output | 3 | Delivery mode sent with the request |
| irq_level | output | 1 | Trigger type sent with the request (1 level, 0 edge) |

## Verification
An expiry can land on the same edge as a register write, and the bench provokes both cases. It counts edges exactly from an initial-count write, so that a second write lands on the eighth edge, which is where a count of 2 expires at a divide of 4. In one run that second write reloads the count. In the other it replaces the entry. The behavioural model in the bench gives the write priority over the expiry, and it samples the entry before the update. On every clock it compares the request, its fields and the read data, and directed checks confirm that the collision dropped the request and loaded the new count, or kept the old vector.

// File: rtl/irq_timer_pkg.sv
// Package: shared types for the countdown interrupt timer.
// Assumes a 32-bit register data path; the entry layout is fixed by R2.
package irq_timer_pkg;

    localparam int DATA_W = 32;

    // Register select codes used by both the write and the read port.
    typedef enum logic [1:0] {
        SEL_ENTRY = 2'd0,
        SEL_INIT  = 2'd1,
        SEL_CURR  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // Decoded vector-table entry; bit 11 and bits 31:18 are not stored.
    typedef struct packed {
        logic       periodic;
        logic       masked;
        logic       level;
        logic       remote;
        logic       polarity;
        logic       status;
        logic [2:0] mode;
        logic [7:0] vector;
    } entry_t;

    // Split a written word into entry fields.
    function automatic entry_t entry_unpack(input logic [DATA_W-1:0] w);
        entry_t e;
        e.vector   = w[7:0];
        e.mode     = w[10:8];
        e.status   = w[12];
        e.polarity = w[13];
        e.remote   = w[14];
        e.level    = w[15];
        e.masked   = w[16];
        e.periodic = w[17];
        return e;
    endfunction

    // Rebuild the read-back word from entry fields.
    function automatic logic [DATA_W-1:0] entry_pack(input entry_t e);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[7:0]   = e.vector;
        w[10:8]  = e.mode;
        w[12]    = e.status;
        w[13]    = e.polarity;
        w[14]    = e.remote;
        w[15]    = e.level;
        w[16]    = e.masked;
        w[17]    = e.periodic;
        return w;
    endfunction

endpackage

// File: rtl/irq_timer_prescale.sv
// Module: fixed clock divider producing a one-cycle tick every 2**DIV_LOG2
// clocks. Assumes restart is a single-cycle strobe; the phase restarts at 0
// so the first tick comes 2**DIV_LOG2 edges after the restart edge (R4).
module irq_timer_prescale #(
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    generate
        if (DIV_LOG2 == 0) begin : g_nodiv
            // Undivided: every clock is a tick.
            assign tick = 1'b1;
        end else begin : g_div
            logic [DIV_LOG2-1:0] phase_q;

            // Free-running phase counter, cleared by reset or restart.
            always_ff @(posedge clk) begin
                if (!rst_n || restart) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end

            assign tick = &phase_q;
        end
    endgenerate

endmodule

// File: rtl/irq_timer_entry.sv
// Module: storage for the vector-table entry. Assumes wr_stb is already
// qualified with the entry select; only the fields of R2 are kept.
module irq_timer_entry
    import irq_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output entry_t            entry,
    output logic [DATA_W-1:0] entry_word
);

    // Capture the written fields; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry <= '0;
        end else if (wr_stb) begin
            entry <= entry_unpack(wr_data);
        end
    end

    assign entry_word = entry_pack(entry);

endmodule

// File: rtl/irq_timer_core.sv
// Module: initial-count and current-count registers with the reload rule.
// Assumes tick is one cycle wide. A load takes priority over an expiry on
// the same edge (R10); expire is the 1 -> 0 step on a tick.
module irq_timer_core #(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [COUNT_W-1:0] load_val,
    input  logic               tick,
    input  logic               periodic,
    output logic [COUNT_W-1:0] init_q,
    output logic [COUNT_W-1:0] cur_q,
    output logic               expire
);

    localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

    assign expire = tick && (cur_q == ONE) && !load;

    // Load, decrement, then reload or stop on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= '0;
            cur_q  <= '0;
        end else if (load) begin
            init_q <= load_val;
            cur_q  <= load_val;
        end else if (tick && (cur_q != '0)) begin
            if (cur_q == ONE) begin
                cur_q <= periodic ? init_q : '0;
            end else begin
                cur_q <= cur_q - ONE;
            end
        end
    end

endmodule

// File: rtl/irq_timer_request.sv
// Module: registers the outgoing request. Assumes expire is a one-cycle
// strobe and entry is the value held before any same-edge write (R10).
module irq_timer_request
    import irq_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire,
    input  entry_t     entry,
    output logic       irq_req,
    output logic [7:0] irq_vector,
    output logic [2:0] irq_mode,
    output logic       irq_level
);

    // Pulse the request when unmasked and latch its fields with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req    <= 1'b0;
            irq_vector <= '0;
            irq_mode   <= '0;
            irq_level  <= 1'b0;
        end else begin
            irq_req <= expire && !entry.masked;
            if (expire && !entry.masked) begin
                irq_vector <= entry.vector;
                irq_mode   <= entry.mode;
                irq_level  <= entry.level;
            end
        end
    end

endmodule

// File: rtl/irq_countdown_timer.sv
// Module: top of the countdown interrupt timer. Decodes the write port,
// muxes read-back data and wires prescaler, entry, counter and request.
// Assumes COUNT_W <= 32; counts wider than the data path are not supported.
module irq_countdown_timer
    import irq_timer_pkg::*;
#(
    parameter int COUNT_W  = 32,
    parameter int DIV_LOG2 = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    output logic        irq_req,
    output logic [7:0]  irq_vector,
    output logic [2:0]  irq_mode,
    output logic        irq_level
);

    logic               load_init;
    logic               load_entry;
    logic               tick;
    logic               expire;
    entry_t             entry_q;
    logic [DATA_W-1:0]  entry_word;
    logic [COUNT_W-1:0] init_count;
    logic [COUNT_W-1:0] cur_count;

    assign load_init  = wr_en && (reg_sel_e'(wr_sel) == SEL_INIT);
    assign load_entry = wr_en && (reg_sel_e'(wr_sel) == SEL_ENTRY);

    irq_timer_prescale #(.DIV_LOG2(DIV_LOG2)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load_init),
        .tick    (tick)
    );

    irq_timer_entry u_entry (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (load_entry),
        .wr_data    (wr_data),
        .entry      (entry_q),
        .entry_word (entry_word)
    );

    irq_timer_core #(.COUNT_W(COUNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_init),
        .load_val (wr_data[COUNT_W-1:0]),
        .tick     (tick),
        .periodic (entry_q.periodic),
        .init_q   (init_count),
        .cur_q    (cur_count),
        .expire   (expire)
    );

    irq_timer_request u_request (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .entry      (entry_q),
        .irq_req    (irq_req),
        .irq_vector (irq_vector),
        .irq_mode   (irq_mode),
        .irq_level  (irq_level)
    );

    // Read-back multiplexer.
    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_ENTRY: rd_data = entry_word;
            SEL_INIT:  rd_data = DATA_W'(init_count);
            SEL_CURR:  rd_data = DATA_W'(cur_count);
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irq_countdown_timer_chk.sv
// Checker: temporal properties of the countdown timer, bound to the top.
// Assumes the top's internal names entry_q, cur_count, init_count, expire.
module irq_countdown_timer_chk
    import irq_timer_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [1:0]         wr_sel,
    input logic [31:0]        wr_data,
    input logic               irq_req,
    input logic [7:0]         irq_vector,
    input entry_t             entry_q,
    input logic [COUNT_W-1:0] cur_count,
    input logic [COUNT_W-1:0] init_count,
    input logic               expire
);

    // R3: an initial-count write lands in the current count.
    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=> (cur_count == $past(wr_data[COUNT_W-1:0])));

    // R4: without a load or an expiry the count never rises.
    assert_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_sel == 2'd1) && !expire) |=> (cur_count <= $past(cur_count)));

    // R5: a request carries the vector held in the previous cycle.
    assert_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector == $past(entry_q.vector)));

    // R6: a request never follows a masked entry.
    assert_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !$past(entry_q.masked));

    // R7: periodic expiry reloads the initial count.
    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && entry_q.periodic) |=> (cur_count == $past(init_count)));

    // R8: one-shot expiry leaves the count at zero.
    assert_oneshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !entry_q.periodic) |=> (cur_count == '0));

    // R9: a stopped counter raises no request.
    assert_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count == '0) |=> !irq_req);

endmodule

bind irq_countdown_timer irq_countdown_timer_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .irq_req    (irq_req),
    .irq_vector (irq_vector),
    .entry_q    (entry_q),
    .cur_count  (cur_count),
    .init_count (init_count),
    .expire     (expire)
);

// File: tb/irq_countdown_timer_test.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks for each requirement.
module irq_countdown_timer_test;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_sel = 2'd2;
    logic [31:0] rd_data;
    logic        irq_req;
    logic [7:0]  irq_vector;
    logic [2:0]  irq_mode;
    logic        irq_level;

    int checks = 0;
    int errors = 0;
    int dut_reqs = 0;
    int mdl_reqs = 0;
    logic [7:0] last_vec = '0;
    logic [2:0] last_mode = '0;
    logic       last_lvl = 1'b0;

    // Reference model state.
    int          m_pre = 0;
    logic [31:0] m_cur = 0, m_init = 0, m_entry = 0;
    logic        m_req = 0;
    logic [7:0]  m_vec = 0;
    logic [2:0]  m_mode = 0;
    logic        m_lvl = 0;

    always #10 clk = ~clk;

    irq_countdown_timer #(.COUNT_W(32), .DIV_LOG2(2)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_req(irq_req), .irq_vector(irq_vector), .irq_mode(irq_mode),
        .irq_level(irq_level)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model update on each edge; the write beats an expiry, the entry is sampled before its write.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cur = 0; m_init = 0; m_entry = 0; m_req = 0;
        end else begin
            bit tk;
            tk = (m_pre == DIV - 1);
            m_req = 0;
            if (wr_en && wr_sel == 2'd1) begin
                m_init = wr_data; m_cur = wr_data; m_pre = 0;
            end else begin
                if (tk && m_cur != 0) begin
                    if (m_cur == 1) begin
                        if (!m_entry[16]) begin
                            m_req = 1; m_vec = m_entry[7:0];
                            m_mode = m_entry[10:8]; m_lvl = m_entry[15];
                        end
                        m_cur = m_entry[17] ? m_init : 0;
                    end else begin
                        m_cur = m_cur - 1;
                    end
                end
                m_pre = (m_pre + 1) % DIV;
            end
            if (wr_en && wr_sel == 2'd0) m_entry = wr_data & 32'h0003F7FF;
        end
    end

    function automatic logic [31:0] m_read(input logic [1:0] s);
        case (s)
            2'd0: return m_entry;
            2'd1: return m_init;
            2'd2: return m_cur;
            default: return 32'd0;
        endcase
    endfunction

    // Per-clock comparison, 5 ns after the edge.
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            chk({31'd0, irq_req}, {31'd0, m_req}, "R5 irq_req");
            if (m_req) begin
                chk({24'd0, irq_vector}, {24'd0, m_vec}, "R5 vector");
                chk({29'd0, irq_mode}, {29'd0, m_mode}, "R5 mode");
                chk({31'd0, irq_level}, {31'd0, m_lvl}, "R5 level");
            end
            chk(rd_data, m_read(rd_sel), "R4 rd_data");
            if (irq_req) begin
                dut_reqs++; last_vec = irq_vector; last_mode = irq_mode; last_lvl = irq_level;
            end
            if (m_req) mdl_reqs++;
        end
    end

    // Drive a write for one edge; call at a falling edge.
    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] s, input logic [31:0] exp, input string tag);
        rd_sel = s; #1;
        chk(rd_data, exp, tag);
        rd_sel = 2'd2;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int base;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_chk(2'd0, 32'd0, "R1 entry");
        rd_chk(2'd1, 32'd0, "R1 init");
        rd_chk(2'd2, 32'd0, "R1 current");
        chk({31'd0, irq_req}, 32'd0, "R1 irq_req");

        // R2 entry layout and readback
        wr(2'd0, 32'hFFFCFD41);
        rd_chk(2'd0, 32'h0000F541, "R2 entry readback");
        rd_chk(2'd3, 32'd0, "R3 unused select");

        // R3/R4 load and decrement timing
        wr(2'd1, 32'd10);
        rd_chk(2'd1, 32'd10, "R3 init");
        rd_chk(2'd2, 32'd10, "R3 current");
        idle(3);
        rd_chk(2'd2, 32'd10, "R4 before tick");
        idle(1);
        rd_chk(2'd2, 32'd9, "R4 first decrement");

        // R5/R8 one-shot expiry
        base = dut_reqs;
        wr(2'd1, 32'd3);
        idle(30);
        chk(dut_reqs - base, 1, "R5 one request");
        chk({24'd0, last_vec}, 32'h41, "R5 vector");
        chk({29'd0, last_mode}, 32'd5, "R5 mode");
        chk({31'd0, last_lvl}, 32'd1, "R5 level");
        rd_chk(2'd2, 32'd0, "R8 holds zero");
        idle(30);
        chk(dut_reqs - base, 1, "R8 no further request");

        // R6 masked periodic
        wr(2'd0, 32'h00030041);
        base = dut_reqs;
        wr(2'd1, 32'd2);
        idle(41);
        chk(dut_reqs - base, 0, "R6 masked no request");
        checks++;
        if (rd_data == 0) begin
            errors++;
            $display("FAIL R6 count stopped actual=%h expected=nonzero", rd_data);
        end

        // R7 periodic, initial count 1
        wr(2'd0, 32'h00028077);
        base = dut_reqs;
        begin
            int mb;
            mb = mdl_reqs;
            wr(2'd1, 32'd1);
            idle(40);
            chk(dut_reqs - base, mdl_reqs - mb, "R7 request count");
            chk((dut_reqs - base >= 9) ? 1 : 0, 1, "R7 every tick");
            chk({24'd0, last_vec}, 32'h77, "R7 vector");
        end

        // R9 write zero stops
        wr(2'd1, 32'd0);
        base = dut_reqs;
        idle(20);
        rd_chk(2'd2, 32'd0, "R9 stopped");
        chk(dut_reqs - base, 0, "R9 no request");

        // R10 initial-count write on the expiring edge
        wr(2'd0, 32'h00000041);
        base = dut_reqs;
        wr(2'd1, 32'd2);
        idle(7);
        wr(2'd1, 32'd5);
        rd_chk(2'd2, 32'd5, "R10 write wins");
        idle(2);
        chk(dut_reqs - base, 0, "R10 expiry dropped");
        idle(30);

        // R10 entry write on the expiring edge
        base = dut_reqs;
        wr(2'd1, 32'd2);
        idle(7);
        wr(2'd0, 32'h00000099);
        idle(2);
        chk(dut_reqs - base, 1, "R10 request kept");
        chk({24'd0, last_vec}, 32'h41, "R10 old vector");

        // R11 writes to other selects ignored
        wr(2'd2, 32'h00001234);
        wr(2'd3, 32'hFFFFFFFF);
        rd_chk(2'd0, 32'h00000099, "R11 entry");
        rd_chk(2'd1, 32'd2, "R11 init");
        rd_chk(2'd2, 32'd0, "R11 current");

        idle(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule